// File: doc/BRIEF.md
# Address Bank Decoder and Cross-Bus Router

This block sits in front of a set of memory-cycle sequencers and decides, for each external transfer, which memory bank the address falls in, which sequencer must run the cycle, and on which of two buses the cycle is carried out. Requests arrive from either the primary system bus or the local bus. The request carries a source flag and an address.

A table of bank descriptors holds the decode rules. Each descriptor has a base address, an address mask, an enable bit and a sequencer number. A second, smaller table assigns every sequencer to one of the two buses. Both tables are loaded through simple write strobes. Every request is decoded in one clock, and the outcome is registered.

The routing across buses is deliberately one-sided. Traffic from the primary bus that decodes to a sequencer owned by the local bus is passed on to the local bus. Traffic from the local bus that decodes to a sequencer owned by the primary bus is dropped, and no cycle starts. A request that decodes to no bank also starts nothing, and it is flagged as a miss.

Top module: `bank_route_unit`

## Requirements
- R1: After reset, every bank is disabled, every sequencer is assigned to the primary bus (bus code 0), and `res_valid`, `res_start`, `res_drop` and `res_nohit` are 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and is 0 after a cycle with `req_valid` low.
- R3: Bank b matches when it is enabled and `(req_addr & mask_b) == (base_b & mask_b)`. Address and base bits outside the mask have no effect, and a disabled bank never matches.
- R4: When several banks match, `res_bank` reports the lowest-numbered one.
- R5: On a hit, `res_seq` equals the sequencer number stored in the winning bank's descriptor.
- R6: A primary-bus request (`req_src`=0) that hits a bank whose sequencer is on the primary bus gives `res_start`=1 and `res_target`=0.
- R7: A primary-bus request that hits a bank whose sequencer is on the local bus (bus code 1) is forwarded: `res_start`=1 and `res_target`=1.
- R8: A local-bus request (`req_src`=1) that hits a bank whose sequencer is on the local bus gives `res_start`=1 and `res_target`=1.
- R9: A local-bus request that hits a bank whose sequencer is on the primary bus is dropped: `res_drop`=1, `res_start`=0, `res_target`=0, and the bank and sequencer are still reported.
- R10: A request that matches no bank gives `res_nohit`=1, `res_start`=0, `res_drop`=0, with `res_bank`, `res_seq` and `res_target` all 0.
- R11: A table write takes effect from the cycle after its strobe. A request in the same cycle as the write is decoded with the old contents.
- R12: Every result has exactly one of `res_start`, `res_drop` and `res_nohit` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_src | input | 1 | Requesting bus: 0 primary, 1 local |
| req_addr | input | ADDR_W | Transfer address |
| bank_wr_en | input | 1 | Bank descriptor write strobe |
| bank_wr_idx | input | IDX_W | Bank number to write |
| bank_wr_base | input | ADDR_W | Base address for the bank |
| bank_wr_mask | input | ADDR_W | Compare mask for the bank |
| bank_wr_valid | input | 1 | Bank enable |
| bank_wr_seq | input | SEQ_W | Sequencer serving the bank |
| seqbus_wr_en | input | 1 | Sequencer bus assignment write strobe |
| seqbus_wr_idx | input | SEQ_W | Sequencer number to assign |
| seqbus_wr_bus | input | 1 | Bus for that sequencer: 0 primary, 1 local |
| res_valid | output | 1 | Result strobe |
| res_bank | output | IDX_W | Winning bank number |
| res_seq | output | SEQ_W | Selected sequencer |
| res_target | output | 1 | Bus that carries the cycle |
| res_start | output | 1 | A sequencer cycle starts |
| res_drop | output | 1 | Local request ignored by the cross-bus rule |
| res_nohit | output | 1 | No bank matched |

## Verification
The bench aims at overlapping banks, where a design that picked the highest or the last match would report the wrong bank number. It checks that a disabled bank with a matching base is skipped and that unmasked address bits and stray base bits are ignored; a design that compared unmasked values would miss, and one that ignored the enable bit would hit. Both cross-bus directions are covered: if the forward or drop paths were swapped or made symmetric, a cycle would start that should be ignored, or a forwarded access would be lost. A table write that lands in the same cycle as a request shows whether the decode uses a bypassed value when it should use the stored one. Idle cycles after a request check that the result strobe does not linger.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic {
    BUS_PRI = 1'b0,
    BUS_LOC = 1'b1
  } bus_e;
endpackage

// File: rtl/bmr_bank_table.sv
// Bank descriptor storage with one address comparator per bank.
module bmr_bank_table #(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 2,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [ADDR_W-1:0]    wr_base,
  input  logic [ADDR_W-1:0]    wr_mask,
  input  logic                 wr_valid,
  input  logic [SEQ_W-1:0]     wr_seq,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic [NUM_BANKS-1:0] hit_vec,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [SEQ_W-1:0]     sel_seq
);

  logic [ADDR_W-1:0] base_q [NUM_BANKS];
  logic [ADDR_W-1:0] mask_q [NUM_BANKS];
  logic [SEQ_W-1:0]  seq_q  [NUM_BANKS];
  logic [NUM_BANKS-1:0] en_q;

  // Single writer process for the whole table; out-of-range index is ignored.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        base_q[b] <= '0;
        mask_q[b] <= '0;
        seq_q[b]  <= '0;
      end
    end else if (wr_en) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wr_idx == IDX_W'(b)) begin
          base_q[b] <= wr_base;
          mask_q[b] <= wr_mask;
          seq_q[b]  <= wr_seq;
          en_q[b]   <= wr_valid;
        end
      end
    end
  end

  // One masked comparator per bank.
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    logic [ADDR_W-1:0] diff;
    assign diff       = (lk_addr ^ base_q[g]) & mask_q[g];
    assign hit_vec[g] = en_q[g] && (diff == '0);
  end

  // Sequencer number of the selected bank.
  always_comb begin
    sel_seq = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_idx == IDX_W'(b)) sel_seq = seq_q[b];
    end
  end

  // R1: table disabled straight after reset
  a_r1_table_cleared: assert property (@(posedge clk)
    rst |=> (hit_vec == '0));

endmodule

// File: rtl/bmr_first_hit.sv
// Lowest-index-wins encoder over the bank hit vector.
module bmr_first_hit #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

  // R4: the chosen bank really hit and no lower bank hit
  always_comb begin
    if (any) begin
      a_r4_chosen_hits: assert (vec[idx]);
      a_r4_none_below: assert ((vec & ((N'(1) << idx) - N'(1))) == '0);
    end
  end

endmodule

// File: rtl/bmr_route.sv
// Sequencer-to-bus table and the cross-bus decision.
module bmr_route #(
  parameter int NUM_SEQ = 3,
  parameter int SEQ_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_idx,
  input  logic             wr_bus,
  input  logic             any_hit,
  input  logic             src,
  input  logic [SEQ_W-1:0] seq,
  output logic             start,
  output logic             drop,
  output logic             nohit,
  output logic             target
);
  import bmr_pkg::*;

  logic [NUM_SEQ-1:0] bus_q;
  logic               seq_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NUM_SEQ; s++) begin
        if (wr_idx == SEQ_W'(s)) bus_q[s] <= wr_bus;
      end
    end
  end

  always_comb begin
    seq_bus = BUS_PRI;
    for (int s = 0; s < NUM_SEQ; s++) begin
      if (seq == SEQ_W'(s)) seq_bus = bus_q[s];
    end
  end

  always_comb begin
    start  = 1'b0;
    drop   = 1'b0;
    nohit  = 1'b0;
    target = BUS_PRI;
    if (!any_hit) begin
      nohit = 1'b1;
    end else begin
      target = seq_bus;
      if (src == BUS_LOC && seq_bus == BUS_PRI) drop = 1'b1;
      else start = 1'b1;
    end
  end

  // R9: only local-bus requests are ever dropped
  always_comb begin
    if (drop) a_r9_drop_src_local: assert (src == BUS_LOC);
  end

endmodule

// File: rtl/bank_route_unit.sv
module bank_route_unit #(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int NUM_SEQ   = 3,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int SEQ_W    = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bank_wr_en,
  input  logic [IDX_W-1:0]  bank_wr_idx,
  input  logic [ADDR_W-1:0] bank_wr_base,
  input  logic [ADDR_W-1:0] bank_wr_mask,
  input  logic              bank_wr_valid,
  input  logic [SEQ_W-1:0]  bank_wr_seq,
  input  logic              seqbus_wr_en,
  input  logic [SEQ_W-1:0]  seqbus_wr_idx,
  input  logic              seqbus_wr_bus,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_bank,
  output logic [SEQ_W-1:0]  res_seq,
  output logic              res_target,
  output logic              res_start,
  output logic              res_drop,
  output logic              res_nohit
);

  logic [NUM_BANKS-1:0] hit_vec;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [SEQ_W-1:0]     win_seq;
  logic                 d_start, d_drop, d_nohit, d_target;

  bmr_bank_table #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(bank_wr_en), .wr_idx(bank_wr_idx), .wr_base(bank_wr_base),
    .wr_mask(bank_wr_mask), .wr_valid(bank_wr_valid), .wr_seq(bank_wr_seq),
    .lk_addr(req_addr), .hit_vec(hit_vec),
    .sel_idx(win_idx), .sel_seq(win_seq)
  );

  bmr_first_hit #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_enc (
    .vec(hit_vec), .any(any_hit), .idx(win_idx)
  );

  bmr_route #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) u_route (
    .clk(clk), .rst(rst),
    .wr_en(seqbus_wr_en), .wr_idx(seqbus_wr_idx), .wr_bus(seqbus_wr_bus),
    .any_hit(any_hit), .src(req_src), .seq(win_seq),
    .start(d_start), .drop(d_drop), .nohit(d_nohit), .target(d_target)
  );

  // Registered result stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_bank   <= '0;
      res_seq    <= '0;
      res_target <= 1'b0;
      res_start  <= 1'b0;
      res_drop   <= 1'b0;
      res_nohit  <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_bank   <= any_hit ? win_idx : '0;
        res_seq    <= any_hit ? win_seq : '0;
        res_target <= d_target;
        res_start  <= d_start;
        res_drop   <= d_drop;
        res_nohit  <= d_nohit;
      end else begin
        res_start <= 1'b0;
        res_drop  <= 1'b0;
        res_nohit <= 1'b0;
      end
    end
  end

  // R2: result strobe tracks the request one cycle later
  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  // R12: exactly one outcome per result
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({res_start, res_drop, res_nohit}) == 1));
  // R8: a started local-bus request stays on the local bus
  a_r8_local_stays_local: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_src) |=> (!res_start || res_target));
  // R10: a miss reports zero bank, sequencer and target
  a_r10_miss_zeroed: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_nohit) |-> (res_bank == '0 && res_seq == '0 && !res_target));

endmodule

// File: tb/bank_route_unit_test.sv
module bank_route_unit_test;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam int SEQ_W  = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_src;
  logic [ADDR_W-1:0] req_addr;
  logic bank_wr_en, bank_wr_valid;
  logic [IDX_W-1:0] bank_wr_idx;
  logic [ADDR_W-1:0] bank_wr_base, bank_wr_mask;
  logic [SEQ_W-1:0] bank_wr_seq;
  logic seqbus_wr_en, seqbus_wr_bus;
  logic [SEQ_W-1:0] seqbus_wr_idx;
  logic res_valid, res_target, res_start, res_drop, res_nohit;
  logic [IDX_W-1:0] res_bank;
  logic [SEQ_W-1:0] res_seq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bank_route_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_addr(req_addr), .bank_wr_en(bank_wr_en), .bank_wr_idx(bank_wr_idx),
    .bank_wr_base(bank_wr_base), .bank_wr_mask(bank_wr_mask),
    .bank_wr_valid(bank_wr_valid), .bank_wr_seq(bank_wr_seq),
    .seqbus_wr_en(seqbus_wr_en), .seqbus_wr_idx(seqbus_wr_idx),
    .seqbus_wr_bus(seqbus_wr_bus), .res_valid(res_valid), .res_bank(res_bank),
    .res_seq(res_seq), .res_target(res_target), .res_start(res_start),
    .res_drop(res_drop), .res_nohit(res_nohit)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic write_bank(int idx, logic [31:0] base, logic [31:0] mask, bit en, int seq);
    @(negedge clk);
    bank_wr_en = 1; bank_wr_idx = IDX_W'(idx); bank_wr_base = base;
    bank_wr_mask = mask; bank_wr_valid = en; bank_wr_seq = SEQ_W'(seq);
    @(negedge clk);
    bank_wr_en = 0;
  endtask

  task automatic write_seqbus(int idx, bit bus);
    @(negedge clk);
    seqbus_wr_en = 1; seqbus_wr_idx = SEQ_W'(idx); seqbus_wr_bus = bus;
    @(negedge clk);
    seqbus_wr_en = 0;
  endtask

  // Issue one request and check every result field one cycle later.
  task automatic issue(string req, bit src, logic [31:0] addr, int bank, int seq,
                       bit tgt, bit st, bit dr, bit nh);
    @(negedge clk);
    req_valid = 1; req_src = src; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    chk(req, "valid", 32'(res_valid), 1);
    chk(req, "bank", 32'(res_bank), 32'(bank));
    chk(req, "seq", 32'(res_seq), 32'(seq));
    chk(req, "target", 32'(res_target), 32'(tgt));
    chk(req, "start", 32'(res_start), 32'(st));
    chk(req, "drop", 32'(res_drop), 32'(dr));
    chk(req, "nohit", 32'(res_nohit), 32'(nh));
  endtask

  task automatic t_reset;
    chk("R1", "valid", 32'(res_valid), 0);
    chk("R1", "start", 32'(res_start), 0);
    chk("R1", "drop", 32'(res_drop), 0);
    chk("R1", "nohit", 32'(res_nohit), 0);
    // all banks disabled: any address misses
    issue("R1", 0, 32'h0000_0000, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_setup;
    write_seqbus(1, 1);                                    // seq1 on local bus
    write_bank(2, 32'h1000_0000, 32'hF000_0000, 1, 0);
    write_bank(5, 32'h2000_0000, 32'hF000_0000, 1, 1);
    write_bank(7, 32'h1000_0000, 32'hFF00_0000, 1, 2);
    write_bank(11, 32'h3000_0000, 32'hF000_0000, 0, 2);    // disabled
    write_bank(0, 32'h4000_0000, 32'hFFFF_0000, 1, 1);
    write_bank(9, 32'h5FFF_FFFF, 32'hF000_0000, 1, 2);     // stray base bits
  endtask

  task automatic t_primary;
    issue("R6", 0, 32'h1234_5678, 2, 0, 0, 1, 0, 0);
    issue("R5", 0, 32'h5000_0000, 9, 2, 0, 1, 0, 0);
    issue("R7", 0, 32'h2000_0010, 5, 1, 1, 1, 0, 0);
  endtask

  task automatic t_overlap;
    issue("R4", 0, 32'h1012_0000, 2, 0, 0, 1, 0, 0);
  endtask

  task automatic t_local;
    issue("R8", 1, 32'h2ABC_0000, 5, 1, 1, 1, 0, 0);
    issue("R9", 1, 32'h1000_0000, 2, 0, 0, 0, 1, 0);
  endtask

  task automatic t_match;
    issue("R3", 0, 32'h4000_FFFF, 0, 1, 1, 1, 0, 0);
    issue("R3", 0, 32'h4001_0000, 0, 0, 0, 0, 0, 1);
    issue("R10", 1, 32'h3000_0000, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_strobe;
    @(negedge clk);
    chk("R2", "valid idle", 32'(res_valid), 0);
    @(negedge clk);
    req_valid = 1; req_src = 0; req_addr = 32'h1000_0000;
    @(negedge clk);
    req_addr = 32'hE000_0000;
    chk("R2", "first bank", 32'(res_bank), 2);
    chk("R12", "first start", 32'(res_start), 1);
    @(negedge clk);
    req_valid = 0;
    chk("R2", "second valid", 32'(res_valid), 1);
    chk("R12", "second nohit", 32'(res_nohit), 1);
    chk("R12", "second start", 32'(res_start), 0);
    @(negedge clk);
    chk("R2", "valid after", 32'(res_valid), 0);
  endtask

  task automatic t_same_cycle_write;
    @(negedge clk);
    bank_wr_en = 1; bank_wr_idx = 4'd11; bank_wr_base = 32'h3000_0000;
    bank_wr_mask = 32'hF000_0000; bank_wr_valid = 1; bank_wr_seq = 2'd2;
    req_valid = 1; req_src = 0; req_addr = 32'h3000_0000;
    @(negedge clk);
    bank_wr_en = 0; req_valid = 0;
    chk("R11", "old nohit", 32'(res_nohit), 1);
    issue("R11", 0, 32'h3000_0000, 11, 2, 0, 1, 0, 0);
    // move seq2 to local bus; local request now starts
    write_seqbus(2, 1);
    issue("R11", 1, 32'h3000_0000, 11, 2, 1, 1, 0, 0);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_src = 0; req_addr = '0;
    bank_wr_en = 0; bank_wr_idx = '0; bank_wr_base = '0; bank_wr_mask = '0;
    bank_wr_valid = 0; bank_wr_seq = '0;
    seqbus_wr_en = 0; seqbus_wr_idx = '0; seqbus_wr_bus = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_setup();
    t_primary();
    t_overlap();
    t_local();
    t_match();
    t_strobe();
    t_same_cycle_write();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule